// File: doc/BRIEF.md
# I2C Control-Register Target

This block is a fast-mode I2C target that gives a host controller access to six 8-bit control registers. The system clock oversamples SCL and SDA. The block finds START and STOP conditions on the sampled lines and answers to one fixed 7-bit address. It acknowledges each byte it accepts. SDA is driven open-drain: the block only ever pulls the line low or releases it.

A write transaction carries a pointer byte and then any number of data bytes. The pointer moves forward after every byte and wraps from the last register back to the first. The pointer keeps its value between transactions. A read that comes straight after the address byte therefore continues from where the last access stopped. A random read is a short write that sets the pointer, then a repeated START, then a read. The register contents are always visible on a flat output bus so that the surrounding logic can use them.

Top module: `i2c_reg_target`

## Requirements
- R1: After reset the registers hold 0x32, 0xA1, 0x3E, 0x3E, 0xFF and 0x09 at indices 0 to 5. Register k appears on `regs_o[8k+7:8k]`. The pointer is 0 and SDA is released.
- R2: The target pulls SDA low in the ninth bit (ACK) only when the first byte after a START carries address 0010011 in its upper seven bits. Bit 0 of that byte is 1 for a read and 0 for a write. On any other address it gives no ACK, and SDA stays released until the next START.
- R3: In a write, the byte after the address loads the pointer from its lower five bits and ignores its upper three. Each following data byte is stored at the pointer and acknowledged.
- R4: After each data byte written, the pointer advances by one. From 5 it wraps to 0, so a long burst overwrites the lower registers.
- R5: Some bits are fixed at zero and read back as 0 whatever is written: bits 3 and 2 of register 0, bits 6, 3 and 1 of register 1, and bits 7 to 4 of register 5.
- R6: A read that directly follows the address byte starts at the pointer. The pointer is one past the last register read or written, and it keeps that value across STOP and across transactions that do not touch it.
- R7: A START in the middle of a transaction, including inside a byte, restarts address matching. It leaves the pointer and the registers unchanged, and this is what makes a random read possible.
- R8: In a read, the target sends 8 bits MSB first and then releases SDA. When the host ACKs (SDA low), it sends the next register, wrapping from 5 to 0. When the host NACKs, it stops driving until a STOP or a START.
- R9: Pointer values 6 to 31 are legal. Writes there change no register, reads there return 0x00, and the pointer moves from 31 to 0.
- R10: The SDA drive changes only while SCL is low.
- R11: A STOP ends the transaction and releases SDA.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; samples the bus lines |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |
| regs_o | output | 48 | Register k on bits 8k+7 to 8k |

## Verification
The hardest case to reach is a START that lands inside a byte, after some data bits have already been shifted in. The bench gets there by setting the pointer and sending three bits of a data byte, then issuing a repeated START and a current-address read. The read must return the old register contents, which shows that neither the partial byte nor the pointer was disturbed. Two other cases are also driven deliberately: pointers near 31, to show the 5-bit wrap through the unused range, and a burst that runs past register 5.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
    localparam int DATA_W   = 8;
    localparam int NUM_REGS = 6;
    localparam int PTR_W    = 5;
    localparam int CNT_W    = $clog2(DATA_W) + 1;

    typedef logic [DATA_W-1:0] byte_t;
    typedef logic [PTR_W-1:0]  ptr_t;

    typedef enum logic [2:0] {
        ST_IDLE, ST_ADDR, ST_REG, ST_WDATA, ST_ACK, ST_RDATA, ST_RACK, ST_WAIT
    } bus_state_e;

    // value each register takes in reset
    function automatic byte_t reg_default(input int idx);
        case (idx)
            0:       return 8'h32;
            1:       return 8'hA1;
            2:       return 8'h3E;
            3:       return 8'h3E;
            4:       return 8'hFF;
            5:       return 8'h09;
            default: return 8'h00;
        endcase
    endfunction

    // bits that can hold a one; the others are tied to zero
    function automatic byte_t reg_keep_mask(input int idx);
        case (idx)
            0:       return 8'hF3;
            1:       return 8'hB5;
            5:       return 8'h0F;
            default: return 8'hFF;
        endcase
    endfunction

    function automatic ptr_t ptr_advance(input ptr_t p);
        if (p == ptr_t'(NUM_REGS - 1)) return '0;
        return ptr_t'(p + 1'b1);
    endfunction
endpackage

// File: rtl/i2c_line_sampler.sv
module i2c_line_sampler #(
    parameter int SYNC_LEN = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    localparam int TAP_W = SYNC_LEN + 1;

    logic [TAP_W-1:0] scl_t, sda_t;
    logic scl_p, sda_p;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_t <= '1;
            sda_t <= '1;
        end else begin
            scl_t <= {scl_t[TAP_W-2:0], scl_i};
            sda_t <= {sda_t[TAP_W-2:0], sda_i};
        end
    end

    assign scl_s = scl_t[TAP_W-2];
    assign scl_p = scl_t[TAP_W-1];
    assign sda_s = sda_t[TAP_W-2];
    assign sda_p = sda_t[TAP_W-1];

    assign scl_rise  = scl_s & ~scl_p;
    assign scl_fall  = ~scl_s & scl_p;
    assign start_det = scl_s & scl_p & sda_p & ~sda_s;
    assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/i2c_reg_bank.sv
module i2c_reg_bank
    import i2c_tgt_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_en,
    input  ptr_t                       wr_addr,
    input  byte_t                      wr_data,
    input  ptr_t                       rd_addr,
    output byte_t                      rd_data,
    output logic [NUM_REGS*DATA_W-1:0] regs_flat
);
    byte_t regs [NUM_REGS];

    for (genvar k = 0; k < NUM_REGS; k++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                regs[k] <= reg_default(k);
            else if (wr_en && wr_addr == ptr_t'(k))
                regs[k] <= wr_data & reg_keep_mask(k);
        end
        assign regs_flat[k*DATA_W +: DATA_W] = regs[k];
    end

    always_comb begin
        rd_data = '0;
        for (int k = 0; k < NUM_REGS; k++)
            if (rd_addr == ptr_t'(k)) rd_data = regs[k];
    end

    // R9: a write beyond the last register leaves all contents alone
    assert_oob_write_ignored_R9: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr >= ptr_t'(NUM_REGS)) |=> $stable(regs_flat));
endmodule

// File: rtl/i2c_bus_engine.sv
module i2c_bus_engine
    import i2c_tgt_pkg::*;
#(
    parameter logic [6:0] TARGET_ADDR = 7'h13
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  scl_s,
    input  logic  sda_s,
    input  logic  scl_rise,
    input  logic  scl_fall,
    input  logic  start_det,
    input  logic  stop_det,
    input  byte_t rd_data,
    output ptr_t  ptr,
    output logic  wr_en,
    output byte_t wr_data,
    output logic  sda_oe
);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W);

    bus_state_e       state, after_ack;
    logic [CNT_W-1:0] bit_cnt;
    byte_t            shreg;
    logic             mack;
    logic             byte_end, ptr_inc, ptr_load;

    assign byte_end = scl_fall && (bit_cnt == LAST_BIT) && !start_det && !stop_det;
    assign wr_en    = (state == ST_WDATA) && byte_end;
    assign wr_data  = shreg;
    assign ptr_load = (state == ST_REG) && byte_end;
    assign ptr_inc  = ((state == ST_WDATA) || (state == ST_RDATA)) && byte_end;

    // register pointer: survives STOP and START
    always_ff @(posedge clk) begin
        if (rst)           ptr <= '0;
        else if (ptr_load) ptr <= shreg[PTR_W-1:0];
        else if (ptr_inc)  ptr <= ptr_advance(ptr);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            after_ack <= ST_IDLE;
            bit_cnt   <= '0;
            shreg     <= '0;
            mack      <= 1'b0;
            sda_oe    <= 1'b0;
        end else if (start_det) begin
            state   <= ST_ADDR;
            bit_cnt <= '0;
            sda_oe  <= 1'b0;
        end else if (stop_det) begin
            state  <= ST_IDLE;
            sda_oe <= 1'b0;
        end else begin
            case (state)
                ST_ADDR, ST_REG, ST_WDATA: begin
                    if (scl_rise) begin
                        shreg   <= {shreg[DATA_W-2:0], sda_s};
                        bit_cnt <= bit_cnt + 1'b1;
                    end else if (byte_end) begin
                        bit_cnt   <= '0;
                        sda_oe    <= 1'b1;
                        state     <= ST_ACK;
                        after_ack <= ST_WDATA;
                        if (state == ST_ADDR) begin
                            if (shreg[DATA_W-1:1] == TARGET_ADDR) begin
                                after_ack <= shreg[0] ? ST_RDATA : ST_REG;
                            end else begin
                                sda_oe <= 1'b0;
                                state  <= ST_IDLE;
                            end
                        end
                    end
                end
                ST_ACK: begin
                    if (scl_fall) begin
                        bit_cnt <= '0;
                        state   <= after_ack;
                        if (after_ack == ST_RDATA) begin
                            shreg  <= rd_data;
                            sda_oe <= ~rd_data[DATA_W-1];
                        end else begin
                            sda_oe <= 1'b0;
                        end
                    end
                end
                ST_RDATA: begin
                    if (scl_rise) begin
                        bit_cnt <= bit_cnt + 1'b1;
                    end else if (scl_fall) begin
                        if (bit_cnt == LAST_BIT) begin
                            bit_cnt <= '0;
                            sda_oe  <= 1'b0;
                            state   <= ST_RACK;
                        end else begin
                            shreg  <= {shreg[DATA_W-2:0], 1'b0};
                            sda_oe <= ~shreg[DATA_W-2];
                        end
                    end
                end
                ST_RACK: begin
                    if (scl_rise) begin
                        mack <= ~sda_s;
                    end else if (scl_fall) begin
                        if (mack) begin
                            shreg  <= rd_data;
                            sda_oe <= ~rd_data[DATA_W-1];
                            state  <= ST_RDATA;
                        end else begin
                            state <= ST_WAIT;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    // R10: drive changes only follow a low sampled SCL
    assert_drive_scl_low_R10: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_oe) |-> !$past(scl_s));
    // R2: idle (including after an address mismatch) never pulls SDA
    assert_idle_released_R2: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE) |-> !sda_oe);
    // R11: STOP ends everything
    assert_stop_idle_R11: assert property (@(posedge clk) disable iff (rst)
        stop_det |=> (state == ST_IDLE) && !sda_oe);
    // R7: START reopens address matching and keeps the pointer
    assert_start_keeps_ptr_R7: assert property (@(posedge clk) disable iff (rst)
        start_det |=> (state == ST_ADDR) && (ptr == $past(ptr)));
    // R4: pointer wraps after the last register
    assert_ptr_wrap_R4: assert property (@(posedge clk) disable iff (rst)
        (ptr_inc && ptr == ptr_t'(NUM_REGS - 1)) |=> (ptr == '0));
endmodule

// File: rtl/i2c_reg_target.sv
module i2c_reg_target
    import i2c_tgt_pkg::*;
#(
    parameter logic [6:0] TARGET_ADDR = 7'h13,
    parameter int         SYNC_LEN    = 2
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       scl_i,
    input  logic                       sda_i,
    output logic                       sda_oe_o,
    output logic [NUM_REGS*DATA_W-1:0] regs_o
);
    logic  scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic  wr_en;
    ptr_t  ptr;
    byte_t wr_data, rd_data;

    i2c_line_sampler #(.SYNC_LEN(SYNC_LEN)) u_sampler (
        .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    i2c_bus_engine #(.TARGET_ADDR(TARGET_ADDR)) u_engine (
        .clk(clk), .rst(rst), .scl_s(scl_s), .sda_s(sda_s),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det),
        .rd_data(rd_data), .ptr(ptr), .wr_en(wr_en), .wr_data(wr_data),
        .sda_oe(sda_oe_o)
    );

    i2c_reg_bank u_bank (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(ptr), .wr_data(wr_data),
        .rd_addr(ptr), .rd_data(rd_data), .regs_flat(regs_o)
    );
endmodule

// File: tb/tb_i2c_reg_target.sv
`timescale 1ns/1ps
module tb_i2c_reg_target;
    localparam int QTR = 10;
    localparam logic [7:0] WADDR = 8'h26;
    localparam logic [7:0] RADDR = 8'h27;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_oe;
    logic [47:0] regs;
    wire  sda_bus = sda_m & ~sda_oe;

    int total = 0;
    int bad = 0;
    int r10_bad = 0;
    int mis_oe = 0;
    bit armed = 0;
    bit mis_window = 0;
    bit done = 0;
    logic [7:0] model [6];

    always #2.5 clk = ~clk;

    i2c_reg_target dut (
        .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_bus),
        .sda_oe_o(sda_oe), .regs_o(regs)
    );

    // R10 monitor: drive must not move while SCL is high
    always @(sda_oe) if (armed && scl_m) r10_bad++;
    always @(posedge clk) if (mis_window && sda_oe) mis_oe++;

    task automatic chk(input bit ok, input string req, input logic [47:0] act, input logic [47:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [47:0] model_flat();
        logic [47:0] f;
        for (int k = 0; k < 6; k++) f[k*8 +: 8] = model[k];
        return f;
    endfunction

    task automatic wait_q();
        repeat (QTR) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wait_q(); scl_m = 1'b1; wait_q();
        sda_m = 1'b0; wait_q(); scl_m = 1'b0; wait_q();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wait_q(); scl_m = 1'b1; wait_q();
        sda_m = 1'b1; wait_q();
    endtask

    task automatic bus_bit(input logic b, output logic s);
        sda_m = b; wait_q(); scl_m = 1'b1; wait_q();
        s = sda_bus; wait_q(); scl_m = 1'b0; wait_q();
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) bus_bit(b[i], s);
        bus_bit(1'b1, s);
        ack = ~s;
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] v);
        logic s;
        v = '0;
        for (int i = 0; i < 8; i++) begin
            bus_bit(1'b1, s);
            v = {v[6:0], s};
        end
        bus_bit(~give_ack, s);
    endtask

    task automatic write_burst(input logic [7:0] pbyte, input int n,
                               input logic [7:0] d [8], input string req);
        logic ack;
        bus_start();
        send_byte(WADDR, ack); chk(ack, "R2 address ack", {47'd0, ack}, 48'd1);
        send_byte(pbyte, ack); chk(ack, req, {47'd0, ack}, 48'd1);
        for (int k = 0; k < n; k++) begin
            send_byte(d[k], ack); chk(ack, req, {47'd0, ack}, 48'd1);
        end
        bus_stop();
    endtask

    task automatic read_burst(input bit random, input logic [7:0] pbyte, input int n,
                              input logic [7:0] e [8], input string req);
        logic ack;
        logic [7:0] v;
        bus_start();
        if (random) begin
            send_byte(WADDR, ack); chk(ack, "R2 address ack", {47'd0, ack}, 48'd1);
            send_byte(pbyte, ack); chk(ack, "R3 pointer ack", {47'd0, ack}, 48'd1);
            bus_start();
        end
        send_byte(RADDR, ack); chk(ack, "R2 read address ack", {47'd0, ack}, 48'd1);
        for (int k = 0; k < n; k++) begin
            recv_byte(k != n - 1, v);
            chk(v == e[k], req, {40'd0, v}, {40'd0, e[k]});
        end
        wait_q();
        chk(!sda_oe, "R8 released after NACK", {47'd0, sda_oe}, 48'd0);
        bus_stop();
    endtask

    task automatic t_reset();
        for (int k = 0; k < 6; k++) model[k] = 8'h00;
        model[0] = 8'h32; model[1] = 8'hA1; model[2] = 8'h3E;
        model[3] = 8'h3E; model[4] = 8'hFF; model[5] = 8'h09;
        chk(regs == model_flat(), "R1 reset values", regs, model_flat());
        chk(!sda_oe, "R1 SDA released", {47'd0, sda_oe}, 48'd0);
    endtask

    task automatic t_current_read_wrap();
        // R6 + R8: pointer starts at 0, burst wraps from 5 to 0
        read_burst(0, 8'h00, 7, '{8'h32, 8'hA1, 8'h3E, 8'h3E, 8'hFF, 8'h09, 8'h32, 8'h00},
                   "R8 current read with wrap");
    endtask

    task automatic t_burst_write();
        // R3: upper bits of 0xE2 ignored -> pointer 2; R4 wrap; R5 masks
        write_burst(8'hE2, 5, '{8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h00, 8'h00, 8'h00},
                    "R3 write ack");
        model[2] = 8'h11; model[3] = 8'h22; model[4] = 8'h33;
        model[5] = 8'h04; model[0] = 8'h51;
        wait_q();
        chk(regs == model_flat(), "R4 burst write with wrap", regs, model_flat());
    endtask

    task automatic t_current_after_write();
        read_burst(0, 8'h00, 1, '{8'hA1, 0, 0, 0, 0, 0, 0, 0}, "R6 current read after write");
    endtask

    task automatic t_random_read();
        read_burst(1, 8'h05, 2, '{8'h04, 8'h51, 0, 0, 0, 0, 0, 0}, "R7 random read");
    endtask

    task automatic t_zero_bits();
        write_burst(8'h05, 3, '{8'hFF, 8'hFF, 8'hFF, 0, 0, 0, 0, 0}, "R5 write ack");
        model[5] = 8'h0F; model[0] = 8'hF3; model[1] = 8'hB5;
        wait_q();
        chk(regs == model_flat(), "R5 fixed zero bits on regs_o", regs, model_flat());
        read_burst(1, 8'h05, 3, '{8'h0F, 8'hF3, 8'hB5, 0, 0, 0, 0, 0}, "R5 fixed zero bits read");
    endtask

    task automatic t_out_of_range();
        write_burst(8'h07, 2, '{8'hAA, 8'hBB, 0, 0, 0, 0, 0, 0}, "R9 write ack");
        wait_q();
        chk(regs == model_flat(), "R9 write above 5 ignored", regs, model_flat());
        read_burst(1, 8'h1E, 3, '{8'h00, 8'h00, 8'hF3, 0, 0, 0, 0, 0}, "R9 read above 5 and 31->0");
    endtask

    task automatic t_mismatch();
        logic ack;
        bus_start();
        mis_window = 1;
        send_byte(8'h28, ack);
        chk(!ack, "R2 foreign address not acked", {47'd0, ack}, 48'd0);
        send_byte(8'h00, ack);
        send_byte(8'h55, ack);
        mis_window = 0;
        chk(mis_oe == 0, "R2 SDA released after mismatch", mis_oe, 0);
        bus_stop();
        chk(regs == model_flat(), "R2 no write after mismatch", regs, model_flat());
        read_burst(0, 8'h00, 1, '{8'hB5, 0, 0, 0, 0, 0, 0, 0}, "R6 pointer kept across mismatch");
    endtask

    task automatic t_start_midbyte();
        logic ack, s;
        logic [7:0] v;
        bus_start();
        send_byte(WADDR, ack);
        send_byte(8'h03, ack); chk(ack, "R3 pointer ack", {47'd0, ack}, 48'd1);
        bus_bit(1'b1, s); bus_bit(1'b0, s); bus_bit(1'b1, s);
        bus_start();
        send_byte(RADDR, ack); chk(ack, "R7 read after mid-byte START", {47'd0, ack}, 48'd1);
        recv_byte(1'b0, v);
        chk(v == 8'h22, "R7 pointer kept by mid-byte START", {40'd0, v}, 48'h22);
        bus_stop();
        wait_q();
        chk(regs == model_flat(), "R7 partial byte not written", regs, model_flat());
    endtask

    task automatic t_stop_release();
        logic ack;
        bus_start();
        send_byte(WADDR, ack);
        bus_stop();
        wait_q();
        chk(!sda_oe, "R11 STOP releases SDA", {47'd0, sda_oe}, 48'd0);
        read_burst(0, 8'h00, 1, '{8'h33, 0, 0, 0, 0, 0, 0, 0}, "R11 pointer after address-only write");
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        repeat (10) @(negedge clk);
        rst = 1'b0;
        repeat (5) @(negedge clk);
        armed = 1;
        t_reset();
        t_current_read_wrap();
        t_burst_write();
        t_current_after_write();
        t_random_read();
        t_zero_bits();
        t_out_of_range();
        t_mismatch();
        t_start_midbyte();
        t_stop_release();
        chk(r10_bad == 0, "R10 drive changes only with SCL low", r10_bad, 0);
        done = 1;
        summary();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            summary();
            $finish;
        end
    end
endmodule